// File: doc/BRIEF.md
# Two-Stage I2C Bit-Clock Divider

This block turns a fast module clock into the bit timing for an I2C master. A prescaler divides the module clock by a value from 1 to 4 and issues a one-cycle internal tick. A phase counter then counts those ticks through one SCL period of 8*SCGD+20 ticks. The period has a low half followed by a high half. At each phase boundary the block pulses a strobe for the master engine. In the middle of each half it pulses a strobe that marks when to drive SDA (low half) or sample SDA (high half).

Both divider fields sit in one 8-bit setting word. The word is written through a simple write port. A write only reaches the live counters while no transfer is running, so a write made during a transfer is held back until the transfer ends. When a transfer begins, both counters start over at the first tick of the low half. In the high half, an SCL line that is still low (a slave stretching the clock) freezes the count until the line is released. Choosing the divider values for a target bit rate is left to the software.

The limit on the internal clock rate (below 20 MHz) is met by choosing a suitable prescale value. The block itself does not check it.

Top module: `i2c_sclk_div`

## Requirements
- R1: While `run` is low, including straight after reset, `tick`, `scl_rise`, `scl_fall`, `sda_drive` and `sda_sample` are all 0 and `scl_hi` is 1.
- R2: The prescale field CDF is bits [1:0] of the setting word. While `run` is high, `tick` pulses once every CDF+1 cycles. The first pulse comes in the (CDF+1)-th cycle of the transfer.
- R3: The period field SCGD is bits [7:2] of the setting word. Consecutive `scl_fall` pulses are exactly (8*SCGD+20)*(CDF+1) cycles apart.
- R4: A period is split into a low half of ceil(P/2) ticks and then a high half of floor(P/2) ticks. `scl_rise` pulses on the last tick of the low half and `scl_fall` on the last tick of the high half, and the two never pulse together.
- R5: `sda_drive` pulses on tick number floor(L/2)+1 of the low half. `sda_sample` pulses on tick number floor(H/2)+1 of the high half. Here L and H are the lengths of the two halves.
- R6: When `run` rises, timing restarts at the first tick of the low half, and `scl_hi` is 0 in the first cycle. Lowering `run` clears both counters.
- R7: A high-half tick that sees `scl_in` low does not advance the count. A low `scl_in` during the low half has no effect.
- R8: A write while `run` is low takes effect at the next transfer. Of several idle writes, the last one wins.
- R9: A write while `run` is high leaves the running transfer's timing unchanged and takes effect at the transfer after it.
- R10: Every edge or SDA strobe coincides with a `tick` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divider setting word |
| cfg_wdata | input | 8 | Setting word: SCGD in [7:2], CDF in [1:0] |
| run | input | 1 | High while a transfer is in progress |
| scl_in | input | 1 | Synchronized level of the SCL line |
| tick | output | 1 | Prescaled internal clock enable |
| scl_rise | output | 1 | Pulse: end of low half, release SCL |
| scl_fall | output | 1 | Pulse: end of high half, pull SCL low |
| sda_drive | output | 1 | Pulse: middle of low half, change SDA |
| sda_sample | output | 1 | Pulse: middle of high half, sample SDA |
| scl_hi | output | 1 | Wanted SCL level (1 = released) |

## Verification
The assertions check on every cycle that:
- no tick appears while idle and ticks are never too close together;
- strobes only occur on a tick and rise and fall never coincide;
- the phase count stays within its half and holds still while stretched;
- the active setting stays frozen through a transfer.

Only the bench scenarios can show the absolute timing: the cycle at which each strobe lands for several divider settings, how much a stretch delays the falling edge, and whether an idle write or a deferred write shows up in the right transfer.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;
  localparam int CDF_W  = 2;
  localparam int SCGD_W = 6;
  localparam int CFG_W  = CDF_W + SCGD_W;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  typedef struct packed {
    logic [SCGD_W-1:0] scgd;
    logic [CDF_W-1:0]  cdf;
  } div_cfg_t;
endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg
  import i2c_sclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  div_cfg_t wr_data,
  input  logic     run,
  output div_cfg_t active
);
  div_cfg_t pend_q, pend_d;
  div_cfg_t act_q, act_d;

  always_comb begin
    pend_d = wr_en ? wr_data : pend_q;
    act_d  = run ? act_q : pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign active = act_q;

  // R9: the live setting never moves while a transfer runs
  a_r9_hold_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(act_q));
endmodule

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div_m1,
  output logic         tick
);
  logic [W-1:0] pcnt_q, pcnt_d;
  logic         hit;

  always_comb begin
    hit = run && (pcnt_q == div_m1);
    if (!run)     pcnt_d = '0;
    else if (hit) pcnt_d = '0;
    else          pcnt_d = pcnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick = hit;

  a_r1_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (div_m1 != '0 && $past(tick)) |-> !tick);
endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
  import i2c_sclk_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          scl_in,
  input  logic [CW-1:0] low_len,
  input  logic [CW-1:0] high_len,
  output logic          scl_rise,
  output logic          scl_fall,
  output logic          sda_drive,
  output logic          sda_sample,
  output logic          scl_hi
);
  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stretch, advance, low_end, high_end;

  always_comb begin
    stretch  = (ph_q == PH_HIGH) && !scl_in;
    advance  = tick && !stretch;
    low_end  = (ph_q == PH_LOW)  && (cnt_q == low_len - CW'(1));
    high_end = (ph_q == PH_HIGH) && (cnt_q == high_len - CW'(1));
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!run) begin
      ph_d  = PH_LOW;
      cnt_d = '0;
    end else if (advance) begin
      if (low_end) begin
        ph_d  = PH_HIGH;
        cnt_d = '0;
      end else if (high_end) begin
        ph_d  = PH_LOW;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOW;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign scl_rise   = advance && low_end;
  assign scl_fall   = advance && high_end;
  assign sda_drive  = advance && (ph_q == PH_LOW)  && (cnt_q == (low_len >> 1));
  assign sda_sample = advance && (ph_q == PH_HIGH) && (cnt_q == (high_len >> 1));
  assign scl_hi     = !run || (ph_q == PH_HIGH);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph_q == PH_LOW) |-> (cnt_q < low_len));
  a_r4_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall}));
  a_r7_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && ph_q == PH_HIGH && !scl_in) |=> (!run || $stable(cnt_q)));
  a_r10_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise || scl_fall || sda_drive || sda_sample) |-> tick);
endmodule

// File: rtl/i2c_sclk_div.sv
module i2c_sclk_div
  import i2c_sclk_pkg::*;
#(
  parameter int PERIOD_BASE = 20,
  parameter int PERIOD_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             run,
  input  logic             scl_in,
  output logic             tick,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             sda_drive,
  output logic             sda_sample,
  output logic             scl_hi
);
  localparam int MAX_PERIOD = PERIOD_BASE + PERIOD_STEP * ((1 << SCGD_W) - 1);
  localparam int PW         = $clog2(MAX_PERIOD + 2);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  div_cfg_t       cfg_live;
  logic [PW-1:0]  period, low_len, high_len;

  sclk_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (cfg_we),
    .wr_data (div_cfg_t'(cfg_wdata)),
    .run     (run),
    .active  (cfg_live)
  );

  always_comb begin
    period   = PW'(PERIOD_BASE) + PW'(PERIOD_STEP) * PW'(cfg_live.scgd);
    low_len  = (period + PW'(1)) >> 1;
    high_len = period >> 1;
  end

  sclk_prescale #(.W(CDF_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (run),
    .div_m1 (cfg_live.cdf),
    .tick   (tick)
  );

  sclk_phase #(.CW(PW)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .run        (run),
    .tick       (tick),
    .scl_in     (scl_in),
    .low_len    (low_len),
    .high_len   (high_len),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_drive  (sda_drive),
    .sda_sample (sda_sample),
    .scl_hi     (scl_hi)
  );
endmodule

// File: tb/i2c_sclk_div_test.sv
module i2c_sclk_div_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       run;
  logic       scl_in;
  logic       tick, scl_rise, scl_fall, sda_drive, sda_sample, scl_hi;

  int checks = 0;
  int fails  = 0;

  // first-occurrence indices recorded by measure()
  int r1, f1, f2, d1, s1, t1, t2, hi0, orphan;

  i2c_sclk_div uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .run(run), .scl_in(scl_in), .tick(tick), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_drive(sda_drive), .sda_sample(sda_sample),
    .scl_hi(scl_hi)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int cdf, input int scgd);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = 8'((scgd << 2) | cdf);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Runs one transfer window of n cycles; index 0 is the first cycle with run high.
  task automatic measure(input int n, input int st_a, input int st_n,
                         input int wr_at, input int wr_val);
    r1 = -1; f1 = -1; f2 = -1; d1 = -1; s1 = -1; t1 = -1; t2 = -1;
    hi0 = -1; orphan = 0;
    @(negedge clk);
    run = 1'b1;
    for (int j = 0; j < n; j++) begin
      if (j > 0) @(negedge clk);
      scl_in    = (j >= st_a && j < st_a + st_n) ? 1'b0 : 1'b1;
      cfg_we    = (j == wr_at);
      cfg_wdata = 8'(wr_val);
      #1;
      if (j == 0) hi0 = int'(scl_hi);
      if (scl_rise && r1 < 0) r1 = j;
      if (scl_fall) begin
        if (f1 < 0) f1 = j;
        else if (f2 < 0) f2 = j;
      end
      if (sda_drive && d1 < 0) d1 = j;
      if (sda_sample && s1 < 0) s1 = j;
      if (tick) begin
        if (t1 < 0) t1 = j;
        else if (t2 < 0) t2 = j;
      end
      if ((scl_rise || scl_fall || sda_drive || sda_sample) && !tick) orphan++;
    end
    @(negedge clk);
    run    = 1'b0;
    cfg_we = 1'b0;
    scl_in = 1'b1;
    #1;
  endtask

  task automatic check_idle(input string req);
    chk(req, int'(tick), 0);
    chk(req, int'(scl_rise | scl_fall | sda_drive | sda_sample), 0);
    chk(req, int'(scl_hi), 1);
  endtask

  task automatic t_reset;
    #1;
    check_idle("R1 reset");
  endtask

  task automatic t_base;  // CDF=0 SCGD=0: P=20, L=H=10
    write_cfg(0, 0);
    measure(44, 999, 0, -1, 0);
    chk("R6 start low", hi0, 0);
    chk("R2 first tick", t1, 0);
    chk("R4 rise", r1, 9);
    chk("R3 fall", f1, 19);
    chk("R3 second fall", f2, 39);
    chk("R5 drive", d1, 5);
    chk("R5 sample", s1, 15);
    chk("R10 strobe w/o tick", orphan, 0);
    check_idle("R1 after run");
  endtask

  task automatic t_prescale;  // CDF=3 SCGD=1: P=28, x4
    write_cfg(3, 1);
    measure(230, 999, 0, -1, 0);
    chk("R2 first tick", t1, 3);
    chk("R2 tick spacing", t2, 7);
    chk("R4 rise", r1, 55);
    chk("R3 fall", f1, 111);
    chk("R3 second fall", f2, 223);
    chk("R5 drive", d1, 31);
    chk("R10 strobe w/o tick", orphan, 0);
  endtask

  task automatic t_mid;  // CDF=1 SCGD=2: P=36, x2
    write_cfg(1, 2);
    measure(150, 999, 0, -1, 0);
    chk("R3 fall", f1, 71);
    chk("R3 second fall", f2, 143);
    chk("R5 sample", s1, 2 * (18 + 9 + 1) - 1);
  endtask

  task automatic t_stretch;
    write_cfg(0, 0);
    measure(30, 10, 7, -1, 0);
    chk("R7 stretched fall", f1, 26);
    chk("R7 rise unaffected", r1, 9);
    measure(30, 2, 5, -1, 0);
    chk("R7 low-half scl_in ignored rise", r1, 9);
    chk("R7 low-half scl_in ignored fall", f1, 19);
  endtask

  task automatic t_idle_write;
    write_cfg(0, 1);
    write_cfg(0, 4);  // P=52
    measure(110, 999, 0, -1, 0);
    chk("R8 last idle write", f1, 51);
    chk("R8 second fall", f2, 103);
    chk("R6 restart low", hi0, 0);
  endtask

  task automatic t_deferred;
    write_cfg(0, 0);
    measure(44, 999, 0, 3, (5 << 2));
    chk("R9 running period kept", f1, 19);
    chk("R9 running period kept 2", f2, 39);
    measure(125, 999, 0, -1, 0);  // P=60
    chk("R9 deferred applied", f1, 59);
    chk("R9 deferred rise", r1, 29);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; run = 1'b0; scl_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_base();
    t_prescale();
    t_mid();
    t_stretch();
    t_idle_write();
    t_deferred();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule